// File: doc/BRIEF.md
# Initialization Word Repeat Sequencer

This block decides when a display-side controller sends its 16-bit initialization word to a remote pole-logic chassis, and what the word contains. After reset it always presents one full initialization word, whether a chassis is fitted or not. While an external chassis alarm is held, it presents a fresh full word once per resend interval. When the alarm is withdrawn, the resends stop. If the alarm is never raised, only the single word from start-up is ever sent.

A second kind of word carries only the trip release code. It is raised when the supervisor reports a code that differs from the one the block last knew, or when an operator writes a new code. Bit 7 marks this code-only kind, and it tells the receiver to ignore the targets and mode and to take only the code. Stored targets, mode and the start-up code come in on input ports. Each word goes to a serial frame transmitter over a valid/ready handshake. The resend interval is a parameter counted in clock cycles. Its default is 750 ms at 250 MHz.

Top module: `init_msg_sequencer`

## Requirements
- R1: Word layout: bits [2:0] trip targets, [5:3] current-sense targets, bit 6 pole mode (1 = single-pole), bit 7 code-only flag, bit 8 load-targets flag, bits [15:9] trip release code.
- R2: While reset is held, tx_vld is 0. On the first clock edge with reset released, one full word is presented.
- R3: If chassis_alarm stays low, no word follows the start-up word unless a code change asks for one.
- R4: With chassis_alarm high and tx_rdy held high, the first resend is presented INTERVAL cycles after the first edge at which the alarm is sampled high. Later resends follow every INTERVAL cycles.
- R5: Pulling chassis_alarm low stops further resends. Raising it again restarts the interval count from zero.
- R6: A full word has bit 7 = 0. It carries the trip targets, sense targets, mode and load flag present at launch, and the latest known code.
- R7: A supervisor code that differs from the known code produces one code-only word: bit 7 = 1, bits [8:0] otherwise 0, and bits [15:9] holding the new code. A supervisor code equal to the known code produces no word.
- R8: Every operator code write produces one code-only word carrying the written code, even if the value is unchanged.
- R9: tx_vld and tx_word hold steady until a cycle with tx_rdy high. tx_vld is 0 in the cycle after an accept.
- R10: A code request raised while a word waits for tx_rdy is served next, ahead of any pending full word (CODE_FIRST = 1).
- R11: The known code is loaded from nv_code while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chassis_alarm | input | 1 | Chassis alarm level; low means rescinded |
| trip_tgt | input | TRIP_W | Stored trip targets |
| sense_tgt | input | 6-TRIP_W | Stored current-sense targets |
| single_pole | input | 1 | Pole mode configuration |
| load_tgt | input | 1 | Receiver should load targets |
| nv_code | input | 7 | Stored trip release code, taken during reset |
| sup_code_vld | input | 1 | Supervisor code report strobe |
| sup_code | input | 7 | Supervisor-reported code |
| op_code_wr | input | 1 | Operator code write strobe |
| op_code | input | 7 | Operator-written code |
| tx_rdy | input | 1 | Transmitter accepts the word |
| tx_vld | output | 1 | Word is presented |
| tx_word | output | 16 | Initialization word |

## Verification
A bad pending flag shows at the ports as a word that is missing, extra or out of order within a few cycles of tx_vld falling. The scoreboard queue flags this straight away. A bad interval counter shows as a resend accept that lands on the wrong cycle, which is caught on the first resend after the alarm rises or is re-raised. A bad known-code register shows as a wrong code field in the next word of either kind. It also shows as a code-only word that appears, or fails to appear, after a supervisor report.

// File: rtl/init_msg_pkg.sv
package init_msg_pkg;
   localparam int WORD_W   = 16;
   localparam int TGT_BITS = 6;
   localparam int MODE_BIT = 6;
   localparam int FLAG_BIT = 7;
   localparam int LOAD_BIT = 8;
   localparam int CODE_LSB = 9;
   localparam int CODE_W   = WORD_W - CODE_LSB;
   typedef logic [WORD_W-1:0] init_word_t;
   typedef logic [CODE_W-1:0] rel_code_t;
   typedef enum logic [1:0] {KIND_NONE, KIND_FULL, KIND_CODE} word_kind_e;
endpackage

// File: rtl/init_interval_timer.sv
module init_interval_timer #(
   parameter int INTERVAL = 187_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CNT_W = $clog2(INTERVAL);

   generate
      if (INTERVAL < 3) begin : g_bad_interval
         $error("INTERVAL must be at least 3");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == CNT_W'(INTERVAL - 1));
   assign tick   = run && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt_q <= '0;
      else if (at_end)    cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
   end

   // R4
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/init_code_tracker.sv
module init_code_tracker
   import init_msg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  rel_code_t nv_code,
   input  logic      sup_code_vld,
   input  rel_code_t sup_code,
   input  logic      op_code_wr,
   input  rel_code_t op_code,
   output rel_code_t known_code,
   output logic      code_req
);
   rel_code_t known_q;
   logic      sup_diff;

   assign sup_diff   = sup_code_vld && (sup_code != known_q);
   assign code_req   = op_code_wr || sup_diff;
   assign known_code = known_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          known_q <= nv_code;
      else if (op_code_wr) known_q <= op_code;
      else if (sup_diff)   known_q <= sup_code;
   end

   // R8
   op_write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_code_wr |=> known_q == $past(op_code));
endmodule

// File: rtl/init_word_builder.sv
module init_word_builder
   import init_msg_pkg::*;
#(
   parameter int TRIP_W = 3
) (
   input  logic [TRIP_W-1:0]          trip_tgt,
   input  logic [TGT_BITS-TRIP_W-1:0] sense_tgt,
   input  logic                       single_pole,
   input  logic                       load_tgt,
   input  rel_code_t                  code,
   output init_word_t                 full_word,
   output init_word_t                 code_word
);
   generate
      if (TRIP_W < 1 || TRIP_W > TGT_BITS - 1) begin : g_bad_trip_w
         $error("TRIP_W out of range");
      end
   endgenerate

   assign full_word = {code, load_tgt, 1'b0, single_pole, sense_tgt, trip_tgt};
   assign code_word = {code, 1'b0, 1'b1, 7'b0};
endmodule

// File: rtl/init_send_sched.sv
module init_send_sched
   import init_msg_pkg::*;
#(
   parameter bit CODE_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       resend_tick,
   input  logic       code_req,
   input  init_word_t full_word,
   input  init_word_t code_word,
   input  logic       tx_rdy,
   output logic       tx_vld,
   output init_word_t tx_word
);
   logic       vld_q, full_pend, code_pend;
   logic       pick_code, pick_full, launch;
   init_word_t word_q;
   word_kind_e kind_q;

   generate
      if (CODE_FIRST) begin : g_code_first
         assign pick_code = code_pend;
         assign pick_full = full_pend && !code_pend;
      end else begin : g_full_first
         assign pick_full = full_pend;
         assign pick_code = code_pend && !full_pend;
      end
   endgenerate

   assign launch  = !vld_q && (full_pend || code_pend);
   assign tx_vld  = vld_q;
   assign tx_word = word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q     <= 1'b0;
         word_q    <= '0;
         kind_q    <= KIND_NONE;
         full_pend <= 1'b1;
         code_pend <= 1'b0;
      end else begin
         if (vld_q && tx_rdy) begin
            vld_q  <= 1'b0;
            kind_q <= KIND_NONE;
         end else if (launch) begin
            vld_q  <= 1'b1;
            word_q <= pick_code ? code_word : full_word;
            kind_q <= pick_code ? KIND_CODE : KIND_FULL;
         end
         full_pend <= resend_tick || (full_pend && !(launch && pick_full));
         code_pend <= code_req    || (code_pend && !(launch && pick_code));
      end
   end

   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && !tx_rdy |=> vld_q && $stable(word_q));
   // R9
   accept_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && tx_rdy |=> !vld_q);

   generate
      if (CODE_FIRST) begin : g_prio_chk
         // R10
         code_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_q && code_pend |=> vld_q && word_q[FLAG_BIT]);
      end
   endgenerate
endmodule

// File: rtl/init_msg_sequencer.sv
module init_msg_sequencer
   import init_msg_pkg::*;
#(
   parameter int INTERVAL   = 187_500_000,
   parameter int TRIP_W     = 3,
   parameter bit CODE_FIRST = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       chassis_alarm,
   input  logic [TRIP_W-1:0]          trip_tgt,
   input  logic [TGT_BITS-TRIP_W-1:0] sense_tgt,
   input  logic                       single_pole,
   input  logic                       load_tgt,
   input  logic [CODE_W-1:0]          nv_code,
   input  logic                       sup_code_vld,
   input  logic [CODE_W-1:0]          sup_code,
   input  logic                       op_code_wr,
   input  logic [CODE_W-1:0]          op_code,
   input  logic                       tx_rdy,
   output logic                       tx_vld,
   output logic [WORD_W-1:0]          tx_word
);
   logic       tick, code_req;
   rel_code_t  known_code;
   init_word_t full_word, code_word;

   init_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(chassis_alarm), .tick(tick));

   init_code_tracker u_code (
      .clk(clk), .rst_n(rst_n), .nv_code(nv_code),
      .sup_code_vld(sup_code_vld), .sup_code(sup_code),
      .op_code_wr(op_code_wr), .op_code(op_code),
      .known_code(known_code), .code_req(code_req));

   init_word_builder #(.TRIP_W(TRIP_W)) u_build (
      .trip_tgt(trip_tgt), .sense_tgt(sense_tgt), .single_pole(single_pole),
      .load_tgt(load_tgt), .code(known_code),
      .full_word(full_word), .code_word(code_word));

   init_send_sched #(.CODE_FIRST(CODE_FIRST)) u_sched (
      .clk(clk), .rst_n(rst_n), .resend_tick(tick), .code_req(code_req),
      .full_word(full_word), .code_word(code_word), .tx_rdy(tx_rdy),
      .tx_vld(tx_vld), .tx_word(tx_word));

   // R7
   code_word_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_vld && tx_word[FLAG_BIT] |-> tx_word[LOAD_BIT:0] == 9'h080);
   // R2
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !tx_vld);
endmodule

// File: tb/tb_init_msg_sequencer.sv
module tb_init_msg_sequencer;
   localparam int P = 20;

   logic       clk = 0, rst_n = 0, chassis_alarm = 0, single_pole = 0, load_tgt = 0;
   logic [2:0] trip_tgt = 0, sense_tgt = 0;
   logic [6:0] nv_code = 7'h2A, sup_code = 0, op_code = 0;
   logic       sup_code_vld = 0, op_code_wr = 0, tx_rdy = 1;
   logic       tx_vld;
   logic [15:0] tx_word;

   init_msg_sequencer #(.INTERVAL(P)) dut (.*);

   always #2 clk = ~clk;

   int n_chk = 0, n_bad = 0, cyc = 0, acc_cnt = 0, acc_cyc = 0;
   logic [15:0] exp_q[$];
   string tag = "R2";
   logic prev_vld = 0, prev_rdy = 0, prev_acc = 0;
   logic [15:0] prev_word = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string r, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   function automatic logic [15:0] fullw(logic [6:0] c);
      return {c, load_tgt, 1'b0, single_pole, sense_tgt, trip_tgt};
   endfunction
   function automatic logic [15:0] codew(logic [6:0] c);
      return {c, 9'h080};
   endfunction

   // monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         chk(tx_vld == 0, "R2", tx_vld, 0);
      end else begin
         if (prev_vld && !prev_rdy)
            chk(tx_vld && tx_word == prev_word, "R9", tx_word, prev_word);
         if (prev_acc) chk(!tx_vld, "R9", tx_vld, 0);
         prev_acc = 0;
         if (tx_vld && tx_rdy) begin
            if (exp_q.size() == 0) chk(0, {tag, " unexpected word"}, tx_word, 0);
            else begin
               automatic logic [15:0] e = exp_q.pop_front();
               chk(tx_word == e, tag, tx_word, e);
            end
            acc_cnt++;
            acc_cyc = cyc;
            prev_acc = 1;
         end
      end
      prev_vld = tx_vld; prev_rdy = tx_rdy; prev_word = tx_word;
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_acc(input int n);
      wait (acc_cnt >= n);
      step(1);
   endtask

   initial begin
      int c0, base, t1, t2;
      fork
         begin
            trip_tgt = 3'h5; sense_tgt = 3'h2; single_pole = 1; load_tgt = 1;
            step(3);
            // R11 R1 R6: start-up word carries stored code
            exp_q.push_back(fullw(7'h2A));
            rst_n = 1;
            wait_acc(1);
            // R3: no alarm, nothing more
            tag = "R3"; step(3*P);
            chk(acc_cnt == 1, "R3", acc_cnt, 1);
            // R7: equal supervisor code ignored
            tag = "R7";
            sup_code = 7'h2A; sup_code_vld = 1; step(1); sup_code_vld = 0;
            step(10);
            chk(acc_cnt == 1, "R7", acc_cnt, 1);
            // R7: differing code
            exp_q.push_back(codew(7'h15));
            sup_code = 7'h15; sup_code_vld = 1; step(1); sup_code_vld = 0;
            wait_acc(2);
            // R8: operator write, then same value again
            tag = "R8";
            exp_q.push_back(codew(7'h33));
            op_code = 7'h33; op_code_wr = 1; step(1); op_code_wr = 0;
            wait_acc(3);
            exp_q.push_back(codew(7'h33));
            op_code_wr = 1; step(1); op_code_wr = 0;
            wait_acc(4);
            // R4 R6: periodic resends with new content
            tag = "R4";
            trip_tgt = 3'h3; sense_tgt = 3'h6; single_pole = 0; load_tgt = 0;
            repeat (3) exp_q.push_back(fullw(7'h33));
            chassis_alarm = 1; c0 = cyc;
            wait (acc_cnt >= 5);
            chk(acc_cyc == c0 + P + 1, "R4", acc_cyc, c0 + P + 1);
            t1 = acc_cyc;
            wait (acc_cnt >= 6);
            chk(acc_cyc - t1 == P, "R4", acc_cyc - t1, P);
            t2 = acc_cyc;
            wait (acc_cnt >= 7);
            chk(acc_cyc - t2 == P, "R4", acc_cyc - t2, P);
            step(1);
            // R5: drop stops resends
            tag = "R5";
            chassis_alarm = 0;
            step(3*P);
            chk(acc_cnt == 7, "R5", acc_cnt, 7);
            // R5: re-raise restarts count
            chassis_alarm = 1; step(P/2); chassis_alarm = 0; step(3);
            exp_q.push_back(fullw(7'h33));
            chassis_alarm = 1; c0 = cyc;
            wait (acc_cnt >= 8);
            chk(acc_cyc == c0 + P + 1, "R5", acc_cyc, c0 + P + 1);
            step(1); chassis_alarm = 0;
            step(2*P);
            // R9 R10: held word, queued code served ahead of full
            tag = "R10";
            tx_rdy = 0;
            exp_q.push_back(fullw(7'h33));
            chassis_alarm = 1;
            wait (tx_vld === 1'b1);
            step(1);
            exp_q.push_back(codew(7'h44));
            exp_q.push_back(fullw(7'h44));
            op_code = 7'h44; op_code_wr = 1; step(1); op_code_wr = 0;
            step(2*P);
            base = acc_cnt;
            chk(base == 8, "R9", base, 8);
            tx_rdy = 1; chassis_alarm = 0;
            wait_acc(11);
            step(3*P);
            chk(exp_q.size() == 0 && acc_cnt == 11, "R10", acc_cnt, 11);
         end
         begin
            repeat (20000) @(posedge clk);
            chk(0, "watchdog", cyc, 0);
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule